// File: doc/BRIEF.md
# Translation Unit Control and Fault Register File

This block is the software-visible register bank that sits beside an address translation unit. A 32-bit register port lets software turn translation on and off, point the unit at its root table array, enable out-of-bound checking, and pulse a flush of cached translations. The block passes each of these settings to the translation unit as a plain output level.

In the other direction, the translation unit reports faults to this block as a cause vector and a virtual address. When exception reporting is enabled, a fault sets cause bits in a status register. The first fault's address is kept for software to read. A level interrupt stays high until software writes zero to the status register. The exception-enable control and the fault address share one offset: a write reaches the enable, and a read returns the captured address.

Top module: `mmu_ctl_regs`

## Requirements
- R1: Offset 0x388 holds the translation enable in bit 0. It drives `xlat_enable`, reads back in bit 0, and writing 0 turns translation off.
- R2: Offset 0x38C holds the 32-bit root table-array base. It drives `table_base` and reads back unchanged.
- R3: Offset 0x1AC holds the out-of-bound check enable in bit 28. It drives `oob_check_en` and reads back in bit 28 with the other bits zero.
- R4: Offset 0x184 holds the flush request in bit 4. `flush_strobe` follows the written level of that bit from the cycle after the write.
- R5: A fault (`fault_valid` high with a nonzero `fault_cause`) while exception reporting is enabled ORs the cause into status bits 2:0 at offset 0x384. `irq` is high from the next cycle.
- R6: Writing 0 to offset 0x384 clears all cause bits and drops `irq`. A nonzero write there changes nothing. A fault arriving in the same cycle as the clear is kept as a new first fault.
- R7: Reading offset 0x380 returns the virtual address of the first fault since the status was last zero. Later faults add cause bits but leave the address unchanged.
- R8: Writing offset 0x380 sets exception reporting from bit 0. While it is 0, faults change neither the status nor `irq`.
- R9: All registers and outputs are 0 after reset, and reads of unmapped offsets return 0.
- R10: Read data is registered: `rdata` shows the addressed register one cycle after `rd_en` and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| fault_valid | input | 1 | Fault report from the translation unit |
| fault_cause | input | CAUSE_W | Fault cause bits |
| fault_vaddr | input | DATA_W | Faulting virtual address |
| xlat_enable | output | 1 | Translation enable |
| oob_check_en | output | 1 | Out-of-bound check enable |
| table_base | output | DATA_W | Root table-array base, low word |
| flush_strobe | output | 1 | Flush request level |
| irq | output | 1 | Level fault interrupt |

## Verification
The checker tests several properties on every cycle. The interrupt rises after any enabled fault and cannot rise while reporting is off. A zero write to the status drops the interrupt. The captured address stays stable while a fault is pending. The enable and flush outputs follow their writes. Some behaviours are shown only by the bench's scenarios, since they need a chain of operations:
- the OR-ing of several causes into the status;
- the return of the fault address through the shared offset;
- nonzero status writes being ignored;
- a clear and a fault landing in the same cycle;
- unmapped reads.

// File: rtl/mmu_regs_pkg.sv
package mmu_regs_pkg;
  localparam int NREG      = 6;
  localparam int IX_FLUSH  = 0;
  localparam int IX_OOB    = 1;
  localparam int IX_EXC    = 2;
  localparam int IX_STAT   = 3;
  localparam int IX_CTRL   = 4;
  localparam int IX_TBASE  = 5;

  localparam int FLUSH_BIT = 4;
  localparam int OOB_BIT   = 28;
  localparam int EN_BIT    = 0;
  localparam int EXC_BIT   = 0;

  function automatic int reg_offset(input int ix);
    case (ix)
      IX_FLUSH: return 'h184;
      IX_OOB:   return 'h1AC;
      IX_EXC:   return 'h380;
      IX_STAT:  return 'h384;
      IX_CTRL:  return 'h388;
      default:  return 'h38C;
    endcase
  endfunction
endpackage

// File: rtl/mmu_reg_decode.sv
module mmu_reg_decode
  import mmu_regs_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   hit
);
  for (genvar i = 0; i < NREG; i++) begin : g_hit
    assign hit[i] = (addr == ADDR_W'(reg_offset(i)));
  end
endmodule

// File: rtl/mmu_cfg_regs.sv
module mmu_cfg_regs
  import mmu_regs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [NREG-1:0]   hit,
  input  logic [DATA_W-1:0] wdata,
  output logic              en_q,
  output logic              oob_q,
  output logic              flush_q,
  output logic              exc_q,
  output logic [DATA_W-1:0] tbase_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      oob_q   <= 1'b0;
      flush_q <= 1'b0;
      exc_q   <= 1'b0;
      tbase_q <= '0;
    end else if (wr_en) begin
      if (hit[IX_CTRL])  en_q    <= wdata[EN_BIT];
      if (hit[IX_OOB])   oob_q   <= wdata[OOB_BIT];
      if (hit[IX_FLUSH]) flush_q <= wdata[FLUSH_BIT];
      if (hit[IX_EXC])   exc_q   <= wdata[EXC_BIT];
      if (hit[IX_TBASE]) tbase_q <= wdata;
    end
  end
endmodule

// File: rtl/mmu_fault_log.sv
module mmu_fault_log #(
  parameter int DATA_W  = 32,
  parameter int CAUSE_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               exc_en,
  input  logic               clr,
  input  logic               fault_valid,
  input  logic [CAUSE_W-1:0] fault_cause,
  input  logic [DATA_W-1:0]  fault_vaddr,
  output logic [CAUSE_W-1:0] status_q,
  output logic [DATA_W-1:0]  addr_q,
  output logic               irq_q
);
  logic               ev;
  logic [CAUSE_W-1:0] base;
  logic [CAUSE_W-1:0] status_d;
  logic               capture;

  always_comb begin
    ev       = fault_valid && exc_en && (|fault_cause);
    base     = clr ? '0 : status_q;
    status_d = base | (ev ? fault_cause : '0);
    capture  = ev && (base == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      addr_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      irq_q    <= |status_d;
      if (capture) addr_q <= fault_vaddr;
    end
  end
endmodule

// File: rtl/mmu_ctl_regs.sv
module mmu_ctl_regs
  import mmu_regs_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int CAUSE_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic               fault_valid,
  input  logic [CAUSE_W-1:0] fault_cause,
  input  logic [DATA_W-1:0]  fault_vaddr,
  output logic               xlat_enable,
  output logic               oob_check_en,
  output logic [DATA_W-1:0]  table_base,
  output logic               flush_strobe,
  output logic               irq
);
  logic [NREG-1:0]    hit;
  logic               exc_en_q;
  logic [CAUSE_W-1:0] status_q;
  logic [DATA_W-1:0]  fault_addr_q;
  logic               clr;
  logic [DATA_W-1:0]  rd_val;

  mmu_reg_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(addr), .hit(hit));

  mmu_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .hit(hit), .wdata(wdata),
    .en_q(xlat_enable), .oob_q(oob_check_en), .flush_q(flush_strobe),
    .exc_q(exc_en_q), .tbase_q(table_base)
  );

  assign clr = wr_en && hit[IX_STAT] && (wdata == '0);

  mmu_fault_log #(.DATA_W(DATA_W), .CAUSE_W(CAUSE_W)) u_flt (
    .clk(clk), .rst(rst), .exc_en(exc_en_q), .clr(clr),
    .fault_valid(fault_valid), .fault_cause(fault_cause),
    .fault_vaddr(fault_vaddr), .status_q(status_q),
    .addr_q(fault_addr_q), .irq_q(irq)
  );

  always_comb begin
    rd_val = '0;
    if (hit[IX_CTRL])  rd_val[EN_BIT]    = xlat_enable;
    if (hit[IX_OOB])   rd_val[OOB_BIT]   = oob_check_en;
    if (hit[IX_FLUSH]) rd_val[FLUSH_BIT] = flush_strobe;
    if (hit[IX_STAT])  rd_val[CAUSE_W-1:0] = status_q;
    if (hit[IX_EXC])   rd_val = fault_addr_q;
    if (hit[IX_TBASE]) rd_val = table_base;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_val;
  end
endmodule

// File: rtl/mmu_ctl_regs_chk.sv
module mmu_ctl_regs_chk #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int CAUSE_W = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  addr,
  input logic [DATA_W-1:0]  wdata,
  input logic               fault_valid,
  input logic [CAUSE_W-1:0] fault_cause,
  input logic               exc_en,
  input logic               irq,
  input logic               xlat_enable,
  input logic               flush_strobe,
  input logic [DATA_W-1:0]  fault_addr
);
  logic wr_stat, wr_zero_stat, fault_ev;
  assign wr_stat      = wr_en && (addr == ADDR_W'('h384));
  assign wr_zero_stat = wr_stat && (wdata == '0);
  assign fault_ev     = fault_valid && (|fault_cause);

  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'('h388)) |=> (xlat_enable == $past(wdata[0]))); // R1
  AST_FLUSH_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'('h184)) |=> (flush_strobe == $past(wdata[4]))); // R4
  AST_FAULT_RAISES: assert property (@(posedge clk) disable iff (rst)
    (exc_en && fault_ev) |=> irq); // R5
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
    (wr_zero_stat && !fault_valid) |=> !irq); // R6
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (irq && !wr_zero_stat) |=> $stable(fault_addr)); // R7
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!exc_en && !irq) |=> !irq); // R8
endmodule

bind mmu_ctl_regs mmu_ctl_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CAUSE_W(CAUSE_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .fault_valid(fault_valid), .fault_cause(fault_cause), .exc_en(exc_en_q),
  .irq(irq), .xlat_enable(xlat_enable), .flush_strobe(flush_strobe),
  .fault_addr(fault_addr_q)
);

// File: tb/sim_mmu_ctl_regs.sv
module sim_mmu_ctl_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        fault_valid = 1'b0;
  logic [2:0]  fault_cause = '0;
  logic [31:0] fault_vaddr = '0;
  logic        xlat_enable, oob_check_en, flush_strobe, irq;
  logic [31:0] table_base;

  int checks = 0, failures = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;
  logic        finished = 1'b0;

  always #5 clk = ~clk;

  mmu_ctl_regs u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .fault_valid(fault_valid),
    .fault_cause(fault_cause), .fault_vaddr(fault_vaddr),
    .xlat_enable(xlat_enable), .oob_check_en(oob_check_en),
    .table_base(table_base), .flush_strobe(flush_strobe), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected read value one cycle after each read strobe
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); rd_en = 1'b1; addr = a; exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic fault(input logic [2:0] c, input logic [31:0] va);
    @(negedge clk); fault_valid = 1'b1; fault_cause = c; fault_vaddr = va;
    @(negedge clk); fault_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R9 reset state
    check("R9 irq", {31'b0, irq}, 0);
    check("R9 enable", {31'b0, xlat_enable}, 0);
    check("R9 base", table_base, 0);
    rd(12'h384, 0, "R9 status");
    rd(12'h380, 0, "R9 fault addr");
    rd(12'h004, 0, "R9 unmapped");
    // R1
    wr(12'h388, 32'hFFFF_FFFF);
    check("R1 enable on", {31'b0, xlat_enable}, 1);
    rd(12'h388, 32'h1, "R1 readback");
    wr(12'h388, 32'h0);
    check("R1 enable off", {31'b0, xlat_enable}, 0);
    // R2
    wr(12'h38C, 32'hA5A5_1234);
    check("R2 base out", table_base, 32'hA5A5_1234);
    rd(12'h38C, 32'hA5A5_1234, "R2 readback");
    // R3
    wr(12'h1AC, 32'h1000_0000);
    check("R3 oob on", {31'b0, oob_check_en}, 1);
    rd(12'h1AC, 32'h1000_0000, "R3 readback");
    wr(12'h1AC, 32'hEFFF_FFFF);
    check("R3 oob off", {31'b0, oob_check_en}, 0);
    // R4
    wr(12'h184, 32'h10);
    check("R4 flush high", {31'b0, flush_strobe}, 1);
    wr(12'h184, 32'h0);
    check("R4 flush low", {31'b0, flush_strobe}, 0);
    // R8 disabled faults ignored
    fault(3'b010, 32'h1111_0000);
    check("R8 no irq", {31'b0, irq}, 0);
    rd(12'h384, 0, "R8 status untouched");
    wr(12'h380, 32'h1);
    // R5, R7
    fault(3'b001, 32'hDEAD_B000);
    check("R5 irq", {31'b0, irq}, 1);
    rd(12'h384, 32'h1, "R5 status");
    rd(12'h380, 32'hDEAD_B000, "R7 first addr");
    fault(3'b100, 32'h2222_2000);
    rd(12'h384, 32'h5, "R5 causes or");
    rd(12'h380, 32'hDEAD_B000, "R7 addr kept");
    // R10 hold
    @(negedge clk);
    check("R10 rdata held", rdata, 32'hDEAD_B000);
    // R6
    wr(12'h384, 32'h7);
    check("R6 nonzero write irq", {31'b0, irq}, 1);
    rd(12'h384, 32'h5, "R6 nonzero write ignored");
    wr(12'h384, 32'h0);
    check("R6 irq cleared", {31'b0, irq}, 0);
    rd(12'h384, 0, "R6 status cleared");
    fault(3'b010, 32'h3333_3000);
    rd(12'h380, 32'h3333_3000, "R7 new capture");
    // R6 clear and fault in one cycle
    @(negedge clk);
    wr_en = 1'b1; addr = 12'h384; wdata = 0;
    fault_valid = 1'b1; fault_cause = 3'b100; fault_vaddr = 32'h4444_4000;
    @(negedge clk); wr_en = 1'b0; fault_valid = 1'b0;
    check("R6 same-cycle irq", {31'b0, irq}, 1);
    rd(12'h384, 32'h4, "R6 same-cycle status");
    rd(12'h380, 32'h4444_4000, "R6 same-cycle addr");
    rd(12'h100, 0, "R9 unmapped 2");
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule